// File: doc/BRIEF.md
# Sector Coincidence Trigger

This block builds a three-level coincidence trigger for an antenna array split into azimuthal sectors (16 by default). Every sector owns three antenna clusters: an upper one and a lower one of five antennas each, and a downward-looking one of three antennas. Single-cycle hit pulses from the antenna discriminators arrive at the inputs. Each pulse opens a coincidence window of `WIN` clock cycles for its antenna.

A cluster is declared hit when enough of its open windows overlap. The upper and lower clusters each need 2 of 5, and the downward cluster needs 2 of 3. A sector then triggers in either of two cases. The first is when both its upper and lower clusters are hit. The second is when enough cluster hits (3 by default) appear among the nine clusters of the sector and its two neighbours. The sector ring wraps around. When several sectors qualify in the same cycle, the lowest-numbered one is reported. Each trigger is a one-cycle pulse together with the sector number. The number stays on its output until the next trigger.

After a trigger the block goes dead for `HOLDOFF` cycles. It clears every open window and discards any hit that arrives during that time. Thresholds, window length and dead time are all parameters.

Top module: `coinc_trigger`

## Requirements
- R1: After reset `trigValid` is 0 and `trigSector` is 0.
- R2: A hit opens a window for its antenna. Two hits sampled on clock edges fewer than `WIN` cycles apart overlap and count together. Hits `WIN` or more cycles apart never count together.
- R3: The upper and lower clusters of sector s use input bits `s*5+a` (a = 0..4) of `topHits` and `botHits`. Each cluster is hit when at least `TOP_THR`/`BOT_THR` (2) of its windows are open. One open window is not enough.
- R4: The downward cluster of sector s uses bits `s*3+a` (a = 0..2) of `nadirHits`. It is hit when at least `NAD_THR` (2) of its windows are open.
- R5: A sector triggers when its upper and lower clusters are both hit in the same cycle.
- R6: A sector also triggers when at least `L3_THR` (3) cluster hits lie among the nine clusters of sectors s-1, s and s+1.
- R7: The neighbour relation wraps: sector `NUM_SECTORS-1` and sector 0 are adjacent.
- R8: When several sectors qualify in one cycle, `trigSector` reports the lowest-numbered one.
- R9: After a trigger on edge e, hits sampled on edges e through e+`HOLDOFF` are ignored, and all windows are closed. A hit on edge e+`HOLDOFF`+1 is accepted.
- R10: `trigValid` rises on the second clock edge after the edge that samples the completing hit. It is high for exactly one cycle. `trigSector` changes only together with `trigValid` and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| topHits | input | NUM_SECTORS*TOP_N | Upper-cluster antenna hit pulses |
| botHits | input | NUM_SECTORS*BOT_N | Lower-cluster antenna hit pulses |
| nadirHits | input | NUM_SECTORS*NAD_N | Downward-cluster antenna hit pulses |
| trigValid | output | 1 | One-cycle global trigger pulse |
| trigSector | output | $clog2(NUM_SECTORS) | Sector of the latest trigger |

## Verification
A hit sampled on edge k that completes a coincidence opens its window after edge k. The cluster result registers after edge k+1, and the trigger appears after edge k+2. The bench drives its pulses on falling edges and samples on later falling edges. It expects `trigValid` low after k+1, high with the sector after k+2, and low again after k+3. For cases that must not fire, it watches the output for `WIN`+4 cycles. The window and dead-time boundaries are timed in whole cycles relative to the sampling edge of the first hit or of the trigger: d = `WIN`-1 against d = `WIN`, and e+`HOLDOFF` against e+`HOLDOFF`+1.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  typedef struct packed {
    logic clearAll;    // close all windows and cluster results
    logic acceptHits;  // allow new hits to open windows
    logic fireEn;      // allow a trigger to be issued
  } ctlStrobes_t;
endpackage

// File: rtl/hit_stretcher.sv
module hit_stretcher #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic accept,
  input  logic clear,
  output logic active
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (clear)          remain <= '0;
    else if (accept && hit)  remain <= CW'(WIN);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/cluster_vote.sv
module cluster_vote #(
  parameter int N   = 5,
  parameter int THR = 2
) (
  input  logic [N-1:0] act,
  output logic         hit
);
  localparam int CNTW = $clog2(N + 1) + 1;
  logic [CNTW-1:0] total;

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) total = total + CNTW'(act[i]);
  end

  assign hit = (total >= CNTW'(THR));
endmodule

// File: rtl/coinc_control.sv
module coinc_control
  import coinc_pkg::*;
#(
  parameter int HOLDOFF = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        anyFire,
  output ctlStrobes_t strobes
);
  localparam int HW = $clog2(HOLDOFF + 1);
  typedef enum logic {ST_IDLE, ST_HOLD} ctlState_t;

  ctlState_t state;
  logic [HW-1:0] holdCnt;

  always_comb begin
    strobes.fireEn     = (state == ST_IDLE);
    strobes.acceptHits = (state == ST_IDLE);
    strobes.clearAll   = (state == ST_IDLE) && anyFire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (anyFire) begin
          state   <= ST_HOLD;
          holdCnt <= HW'(HOLDOFF - 1);
        end
        ST_HOLD: if (holdCnt == '0) state <= ST_IDLE;
                 else holdCnt <= holdCnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coinc_datapath.sv
module coinc_datapath
  import coinc_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int TOP_N   = 5,
  parameter int BOT_N   = 5,
  parameter int NAD_N   = 3,
  parameter int WIN     = 4,
  parameter int TOP_THR = 2,
  parameter int BOT_THR = 2,
  parameter int NAD_THR = 2,
  parameter int L3_THR  = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SECTORS*TOP_N-1:0]       topHits,
  input  logic [NUM_SECTORS*BOT_N-1:0]       botHits,
  input  logic [NUM_SECTORS*NAD_N-1:0]       nadirHits,
  input  ctlStrobes_t                        strobes,
  output logic                               anyFire,
  output logic                               trigValid,
  output logic [$clog2(NUM_SECTORS)-1:0]     trigSector
);
  localparam int SW = $clog2(NUM_SECTORS);

  logic [NUM_SECTORS*TOP_N-1:0] topAct;
  logic [NUM_SECTORS*BOT_N-1:0] botAct;
  logic [NUM_SECTORS*NAD_N-1:0] nadAct;
  logic [NUM_SECTORS-1:0] topVote, botVote, nadVote;
  logic [NUM_SECTORS-1:0] l2Top, l2Bot, l2Nad;
  logic [NUM_SECTORS-1:0] sectorFire;
  logic [SW-1:0] lowest;

  // Level 1: per-antenna windows
  for (genvar i = 0; i < NUM_SECTORS*TOP_N; i++) begin : g_topStr
    hit_stretcher #(.WIN(WIN)) str_i (.clk(clk), .rst_n(rst_n), .hit(topHits[i]),
      .accept(strobes.acceptHits), .clear(strobes.clearAll), .active(topAct[i]));
  end
  for (genvar i = 0; i < NUM_SECTORS*BOT_N; i++) begin : g_botStr
    hit_stretcher #(.WIN(WIN)) str_i (.clk(clk), .rst_n(rst_n), .hit(botHits[i]),
      .accept(strobes.acceptHits), .clear(strobes.clearAll), .active(botAct[i]));
  end
  for (genvar i = 0; i < NUM_SECTORS*NAD_N; i++) begin : g_nadStr
    hit_stretcher #(.WIN(WIN)) str_i (.clk(clk), .rst_n(rst_n), .hit(nadirHits[i]),
      .accept(strobes.acceptHits), .clear(strobes.clearAll), .active(nadAct[i]));
  end

  // Level 2: cluster majority per sector
  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_l2
    cluster_vote #(.N(TOP_N), .THR(TOP_THR)) topV_i (.act(topAct[s*TOP_N +: TOP_N]), .hit(topVote[s]));
    cluster_vote #(.N(BOT_N), .THR(BOT_THR)) botV_i (.act(botAct[s*BOT_N +: BOT_N]), .hit(botVote[s]));
    cluster_vote #(.N(NAD_N), .THR(NAD_THR)) nadV_i (.act(nadAct[s*NAD_N +: NAD_N]), .hit(nadVote[s]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.clearAll) begin
      l2Top <= '0;
      l2Bot <= '0;
      l2Nad <= '0;
    end else begin
      l2Top <= topVote;
      l2Bot <= botVote;
      l2Nad <= nadVote;
    end
  end

  // Level 3: in-sector pair and neighbourhood majority
  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_l3
    localparam int PREV = (s + NUM_SECTORS - 1) % NUM_SECTORS;
    localparam int NEXT = (s + 1) % NUM_SECTORS;
    logic [8:0] nbhd;
    logic majHit;
    assign nbhd = {l2Top[PREV], l2Bot[PREV], l2Nad[PREV],
                   l2Top[s],    l2Bot[s],    l2Nad[s],
                   l2Top[NEXT], l2Bot[NEXT], l2Nad[NEXT]};
    cluster_vote #(.N(9), .THR(L3_THR)) l3V_i (.act(nbhd), .hit(majHit));
    assign sectorFire[s] = (l2Top[s] & l2Bot[s]) | majHit;
  end

  always_comb begin
    lowest = '0;
    for (int i = NUM_SECTORS - 1; i >= 0; i--)
      if (sectorFire[i]) lowest = SW'(i);
  end

  assign anyFire = |sectorFire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trigValid  <= 1'b0;
      trigSector <= '0;
    end else begin
      trigValid <= strobes.fireEn && anyFire;
      if (strobes.fireEn && anyFire) trigSector <= lowest;
    end
  end
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import coinc_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int TOP_N   = 5,
  parameter int BOT_N   = 5,
  parameter int NAD_N   = 3,
  parameter int WIN     = 4,
  parameter int HOLDOFF = 8,
  parameter int TOP_THR = 2,
  parameter int BOT_THR = 2,
  parameter int NAD_THR = 2,
  parameter int L3_THR  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SECTORS*TOP_N-1:0]   topHits,
  input  logic [NUM_SECTORS*BOT_N-1:0]   botHits,
  input  logic [NUM_SECTORS*NAD_N-1:0]   nadirHits,
  output logic                           trigValid,
  output logic [$clog2(NUM_SECTORS)-1:0] trigSector
);
  ctlStrobes_t strobes;
  logic anyFire;

  coinc_datapath #(
    .NUM_SECTORS(NUM_SECTORS), .TOP_N(TOP_N), .BOT_N(BOT_N), .NAD_N(NAD_N),
    .WIN(WIN), .TOP_THR(TOP_THR), .BOT_THR(BOT_THR), .NAD_THR(NAD_THR), .L3_THR(L3_THR)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .topHits(topHits), .botHits(botHits),
    .nadirHits(nadirHits), .strobes(strobes), .anyFire(anyFire),
    .trigValid(trigValid), .trigSector(trigSector)
  );

  coinc_control #(.HOLDOFF(HOLDOFF)) ctl_i (
    .clk(clk), .rst_n(rst_n), .anyFire(anyFire), .strobes(strobes)
  );
endmodule

// File: rtl/coinc_trigger_chk.sv
module coinc_trigger_chk #(
  parameter int NUM_SECTORS = 16,
  parameter int TOP_N   = 5,
  parameter int BOT_N   = 5,
  parameter int NAD_N   = 3,
  parameter int WIN     = 4,
  parameter int HOLDOFF = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_SECTORS*TOP_N-1:0]   topHits,
  input logic [NUM_SECTORS*BOT_N-1:0]   botHits,
  input logic [NUM_SECTORS*NAD_N-1:0]   nadirHits,
  input logic                           trigValid,
  input logic [$clog2(NUM_SECTORS)-1:0] trigSector
);
  localparam int SHW = $clog2(WIN + 4) + 1;
  localparam int QW  = $clog2(HOLDOFF + 3) + 1;

  logic anyHit;
  logic [SHW-1:0] sinceHit;
  logic [QW-1:0]  quietCnt;

  assign anyHit = (|topHits) | (|botHits) | (|nadirHits);

  always_ff @(posedge clk) begin
    if (!rst_n)                          sinceHit <= SHW'(WIN + 3);
    else if (anyHit)                     sinceHit <= '0;
    else if (sinceHit != SHW'(WIN + 3))  sinceHit <= sinceHit + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              quietCnt <= '0;
    else if (trigValid)      quietCnt <= QW'(HOLDOFF + 2);
    else if (quietCnt != '0) quietCnt <= quietCnt - 1'b1;
  end

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigValid |=> !trigValid);

  // R10
  sector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trigValid |-> $stable(trigSector));

  // R2
  window_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigValid |-> (sinceHit <= SHW'(WIN + 1)));

  // R9
  dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigValid |-> (quietCnt == '0));
endmodule

bind coinc_trigger coinc_trigger_chk #(
  .NUM_SECTORS(NUM_SECTORS), .TOP_N(TOP_N), .BOT_N(BOT_N), .NAD_N(NAD_N),
  .WIN(WIN), .HOLDOFF(HOLDOFF)
) chk_i (
  .clk(clk), .rst_n(rst_n), .topHits(topHits), .botHits(botHits),
  .nadirHits(nadirHits), .trigValid(trigValid), .trigSector(trigSector)
);

// File: tb/coinc_trigger_tb.sv
module coinc_trigger_tb_top;
  localparam int NS = 16;
  localparam int WIN = 4;
  localparam int HOLDOFF = 8;
  localparam int TW = NS * 5;
  localparam int NW = NS * 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] topHits = '0;
  logic [TW-1:0] botHits = '0;
  logic [NW-1:0] nadirHits = '0;
  logic trigValid;
  logic [3:0] trigSector;

  int testCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  coinc_trigger #(.NUM_SECTORS(NS), .WIN(WIN), .HOLDOFF(HOLDOFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .topHits(topHits), .botHits(botHits),
    .nadirHits(nadirHits), .trigValid(trigValid), .trigSector(trigSector)
  );

  function automatic logic [TW-1:0] clu5(int s, int first, int n);
    logic [TW-1:0] v = '0;
    for (int a = first; a < first + n; a++) v[s*5 + a] = 1'b1;
    return v;
  endfunction

  function automatic logic [NW-1:0] clu3(int s, int n);
    logic [NW-1:0] v = '0;
    for (int a = 0; a < n; a++) v[s*3 + a] = 1'b1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one-cycle pulse: called at a falling edge, returns at the next one
  task automatic pulse(input logic [TW-1:0] t, input logic [TW-1:0] b, input logic [NW-1:0] n);
    topHits = t; botHits = b; nadirHits = n;
    @(negedge clk);
    topHits = '0; botHits = '0; nadirHits = '0;
  endtask

  task automatic expectTrig(input string req, input int sector);
    @(negedge clk);
    check(trigValid == 1'b0, {req, " early"}, trigValid, 0);
    @(negedge clk);
    check(trigValid == 1'b1 && trigSector == 4'(sector), req,
          trigValid ? int'(trigSector) : -1, sector);
    @(negedge clk);
    check(trigValid == 1'b0 && trigSector == 4'(sector), {req, " R10 pulse/hold"},
          trigValid ? -1 : int'(trigSector), sector);
  endtask

  task automatic expectNone(input string req);
    int seen = 0;
    for (int c = 0; c < WIN + 4; c++) begin
      @(negedge clk);
      if (trigValid) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic settle();
    repeat (HOLDOFF + WIN + 6) @(negedge clk);
  endtask

  task automatic t_reset();
    check(trigValid == 1'b0, "R1 trigValid", trigValid, 0);
    check(trigSector == 4'd0, "R1 trigSector", trigSector, 0);
  endtask

  task automatic t_pair();
    pulse(clu5(5, 0, 2), clu5(5, 3, 2), '0);
    expectTrig("R3 R5 top+bottom pair", 5);
    settle();
    pulse(clu5(5, 0, 1), clu5(5, 1, 2), '0);
    expectNone("R3 single top window");
    settle();
  endtask

  task automatic t_neighbour();
    pulse(clu5(8, 0, 2), clu5(6, 2, 2), clu3(7, 2));
    expectTrig("R4 R6 neighbourhood 3 clusters", 7);
    settle();
    pulse(clu5(8, 0, 2), clu5(6, 2, 2), clu3(7, 1));
    expectNone("R4 single nadir window");
    settle();
  endtask

  task automatic t_wrap();
    pulse(clu5(15, 0, 2), clu5(14, 0, 2), clu3(0, 2));
    expectTrig("R7 wrap sector 15", 15);
    settle();
  endtask

  task automatic t_priority();
    pulse(clu5(10, 0, 2) | clu5(3, 1, 2), clu5(10, 2, 2) | clu5(3, 0, 2), '0);
    expectTrig("R8 lowest sector", 3);
    settle();
  endtask

  task automatic t_window();
    // d = WIN-1: overlap
    pulse(clu5(2, 0, 1), '0, '0);
    repeat (WIN - 2) @(negedge clk);
    pulse(clu5(2, 1, 1), clu5(2, 0, 2), '0);
    expectTrig("R2 window d=WIN-1", 2);
    settle();
    // d = WIN: no overlap
    pulse(clu5(2, 0, 1), '0, '0);
    repeat (WIN - 1) @(negedge clk);
    pulse(clu5(2, 1, 1), clu5(2, 0, 2), '0);
    expectNone("R2 window d=WIN");
    settle();
  endtask

  task automatic t_holdoff();
    // last ignored edge e+HOLDOFF
    pulse(clu5(4, 0, 2), clu5(4, 0, 2), '0);
    expectTrig("R9 first trigger", 4);
    repeat (HOLDOFF - 2) @(negedge clk);
    pulse(clu5(9, 0, 2), clu5(9, 0, 2), '0);
    expectNone("R9 hit at e+HOLDOFF ignored");
    check(trigSector == 4'd4, "R9 sector unchanged", trigSector, 4);
    settle();
    // first accepted edge e+HOLDOFF+1
    pulse(clu5(4, 0, 2), clu5(4, 0, 2), '0);
    expectTrig("R9 second trigger", 4);
    repeat (HOLDOFF - 1) @(negedge clk);
    pulse(clu5(9, 0, 2), clu5(9, 0, 2), '0);
    expectTrig("R9 hit at e+HOLDOFF+1 accepted", 9);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pair();
    t_neighbour();
    t_wrap();
    t_priority();
    t_window();
    t_holdoff();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule